// File: doc/BRIEF.md
# Float to 32-bit Integer Converter

This block turns an already-unpacked floating-point operand into a signed 32-bit two's-complement integer. The operand arrives as a class code, a sign, a signed unbiased exponent, a mantissa whose leading one sits at its top bit, and a sticky bit that stands for any precision already dropped upstream. The value of a normal number is the mantissa, read as 1.fff, times two to the exponent.

The integer part is found by shifting the mantissa right until it lands in the low 32 bits. Whatever falls off the right end, together with the incoming sticky bit, decides the inexact flag. The result always truncates toward zero, whatever rounding mode the surrounding unit is in. Operands too large for the integer range, infinities and NaNs saturate. In that case the inexact flag gives way to an operand-error flag.

One result, with both flags, is registered per accepted operand, one clock after `in_valid`.

Top module: `fp2int_conv`

## Requirements
- R1: A zero-class operand (class code 2'b00) gives 0 with both flags low, whatever its sign, exponent, mantissa or sticky bit.
- R2: An infinity (class 2'b10) or NaN (class 2'b11) gives operand error high, inexact low, and 0x7FFFFFFF when the sign is 0 or 0x80000000 when the sign is 1.
- R3: A number (class 2'b01) whose exponent is 32 or more gives the same saturated result and flags as R2.
- R4: For a number that does not overflow, the magnitude of the result is the integer part of 1.fff times two to the exponent, truncated toward zero for both signs. The mantissa's top bit has weight two to the exponent.
- R5: For a number that does not overflow, inexact is high exactly when a mantissa bit shifted out was 1 or the incoming sticky bit is 1. Operand error is low.
- R6: A number with a negative exponent, down to the most negative exponent, gives 0 with operand error low and no underflow indication. Inexact follows R5.
- R7: A magnitude of exactly 0x80000000 is accepted for sign 1 and gives 0x80000000. For sign 0, or for any larger magnitude, the operand overflows as in R2.
- R8: A negative result that does not overflow is the two's-complement negation of the magnitude.
- R9: The result and flags for an operand accepted with `in_valid` high appear with `out_valid` high after exactly one rising clock edge. Each accepted operand replaces both flags. With `in_valid` low, `out_valid` falls and the last result and flags are held.
- R10: Inexact and operand error are never high together.
- R11: During reset, `out_valid`, `out_int` and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand is present this cycle |
| in_class | input | 2 | 00 zero, 01 number, 10 infinity, 11 NaN |
| in_sign | input | 1 | 1 for a negative operand |
| in_exp | input | 16 | Signed unbiased exponent |
| in_mant | input | 40 | Mantissa with the leading one at bit 39 |
| in_sticky | input | 1 | Precision already lost below the mantissa |
| out_valid | output | 1 | Result registered from an accepted operand |
| out_int | output | 32 | Signed integer result |
| out_inexact | output | 1 | Nonzero bits were discarded |
| out_operr | output | 1 | Overflow, infinity or NaN |

## Verification
The operands cover exact and fractional values of both signs. This shows whether truncation goes toward zero and whether negation happens after the magnitude is found. Sticky-only inexactness and bits lost purely to the shift are tried apart, which shows that both feed the flag. The edge of the integer range is probed with magnitudes just below, at and just above 0x80000000 for each sign. The exponent is probed at 31 against 32 and at the most positive value, with negative exponents near and far, and infinities and NaNs with and without sticky. These tell apart an off-by-one in the overflow compare, a missing sign term, and a shifter that mishandles very large shift distances.

// File: rtl/fp2int_pkg.sv
package fp2int_pkg;

  typedef enum logic [1:0] {
    CLS_ZERO = 2'b00,
    CLS_NUM  = 2'b01,
    CLS_INF  = 2'b10,
    CLS_NAN  = 2'b11
  } fp_class_e;

endpackage

// File: rtl/fp2int_align.sv
module fp2int_align #(
  parameter int MANT_W = 40,
  parameter int EXP_W  = 16,
  parameter int INT_W  = 32
) (
  input  logic signed [EXP_W-1:0]  exp_i,
  input  logic        [MANT_W-1:0] mant_i,
  output logic        [INT_W-1:0]  mag_o,
  output logic                     lost_o,
  output logic                     exp_big_o
);

  localparam int SH_W = $clog2(MANT_W + 1);
  localparam int SX_W = EXP_W + 2;

  // shift right by s, return {shifted value, OR of dropped bits}
  function automatic logic [MANT_W:0] shr_sticky(input logic [MANT_W-1:0] m,
                                                 input logic [SH_W-1:0]   s);
    logic [MANT_W-1:0] keep_mask;
    if (s >= SH_W'(MANT_W)) begin
      return {{MANT_W{1'b0}}, |m};
    end
    keep_mask = ~({MANT_W{1'b1}} << s);
    return {m >> s, |(m & keep_mask)};
  endfunction

  logic signed [SX_W-1:0] sh_s;
  logic        [SH_W-1:0] sh_c;
  logic        [MANT_W:0] shr_w;

  assign sh_s      = SX_W'(MANT_W - 1) - SX_W'(exp_i);
  assign exp_big_o = (exp_i > EXP_W'(INT_W - 1));

  always_comb begin
    if (sh_s < 0)                   sh_c = '0;
    else if (sh_s >= SX_W'(MANT_W)) sh_c = SH_W'(MANT_W);
    else                            sh_c = SH_W'(sh_s);
  end

  assign shr_w  = shr_sticky(mant_i, sh_c);
  assign mag_o  = shr_w[INT_W:1];
  assign lost_o = shr_w[0];

endmodule

// File: rtl/fp2int_range.sv
module fp2int_range #(
  parameter int INT_W = 32
) (
  input  fp2int_pkg::fp_class_e cls_i,
  input  logic                  sign_i,
  input  logic                  exp_big_i,
  input  logic [INT_W-1:0]      mag_i,
  output logic                  ovf_o
);
  import fp2int_pkg::*;

  localparam logic [INT_W-1:0] EDGE_MAG = {1'b1, {(INT_W-1){1'b0}}};

  function automatic logic num_ovf(input logic big, input logic s,
                                   input logic [INT_W-1:0] m);
    return big || (m > EDGE_MAG) || ((m == EDGE_MAG) && !s);
  endfunction

  always_comb begin
    unique case (cls_i)
      CLS_ZERO: ovf_o = 1'b0;
      CLS_NUM:  ovf_o = num_ovf(exp_big_i, sign_i, mag_i);
      default:  ovf_o = 1'b1;
    endcase
  end

endmodule

// File: rtl/fp2int_pack.sv
module fp2int_pack #(
  parameter int INT_W = 32
) (
  input  fp2int_pkg::fp_class_e cls_i,
  input  logic                  sign_i,
  input  logic [INT_W-1:0]      mag_i,
  input  logic                  lost_i,
  input  logic                  sticky_i,
  input  logic                  ovf_i,
  output logic [INT_W-1:0]      res_o,
  output logic                  inexact_o,
  output logic                  operr_o
);
  import fp2int_pkg::*;

  function automatic logic [INT_W-1:0] sat_value(input logic s);
    return s ? {1'b1, {(INT_W-1){1'b0}}} : {1'b0, {(INT_W-1){1'b1}}};
  endfunction

  function automatic logic [INT_W-1:0] apply_sign(input logic s,
                                                  input logic [INT_W-1:0] m);
    return s ? (~m + INT_W'(1)) : m;
  endfunction

  always_comb begin
    res_o     = '0;
    inexact_o = 1'b0;
    operr_o   = 1'b0;
    if (ovf_i) begin
      res_o   = sat_value(sign_i);
      operr_o = 1'b1;
    end else if (cls_i == CLS_NUM) begin
      res_o     = apply_sign(sign_i, mag_i);
      inexact_o = lost_i | sticky_i;
    end
  end

endmodule

// File: rtl/fp2int_conv.sv
module fp2int_conv #(
  parameter int MANT_W = 40,
  parameter int EXP_W  = 16,
  parameter int INT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        in_class,
  input  logic              in_sign,
  input  logic [EXP_W-1:0]  in_exp,
  input  logic [MANT_W-1:0] in_mant,
  input  logic              in_sticky,
  output logic              out_valid,
  output logic [INT_W-1:0]  out_int,
  output logic              out_inexact,
  output logic              out_operr
);
  import fp2int_pkg::*;

  localparam logic [INT_W-1:0] POS_SAT = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic [INT_W-1:0] NEG_SAT = {1'b1, {(INT_W-1){1'b0}}};

  fp_class_e               cls_w;
  logic signed [EXP_W-1:0] exp_w;
  logic [INT_W-1:0]        mag_w;
  logic                    lost_w;
  logic                    exp_big_w;
  logic                    ovf_w;
  logic [INT_W-1:0]        res_w;
  logic                    inexact_w;
  logic                    operr_w;

  assign cls_w = fp_class_e'(in_class);
  assign exp_w = in_exp;

  fp2int_align #(.MANT_W(MANT_W), .EXP_W(EXP_W), .INT_W(INT_W)) u_align (
    .exp_i     (exp_w),
    .mant_i    (in_mant),
    .mag_o     (mag_w),
    .lost_o    (lost_w),
    .exp_big_o (exp_big_w)
  );

  fp2int_range #(.INT_W(INT_W)) u_range (
    .cls_i     (cls_w),
    .sign_i    (in_sign),
    .exp_big_i (exp_big_w),
    .mag_i     (mag_w),
    .ovf_o     (ovf_w)
  );

  fp2int_pack #(.INT_W(INT_W)) u_pack (
    .cls_i     (cls_w),
    .sign_i    (in_sign),
    .mag_i     (mag_w),
    .lost_i    (lost_w),
    .sticky_i  (in_sticky),
    .ovf_i     (ovf_w),
    .res_o     (res_w),
    .inexact_o (inexact_w),
    .operr_o   (operr_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_int     <= '0;
      out_inexact <= 1'b0;
      out_operr   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_int     <= res_w;
        out_inexact <= inexact_w;
        out_operr   <= operr_w;
      end
    end
  end

  // ---- assertions ----
  p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(out_int) && $stable(out_operr));

  p_flags_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_inexact && out_operr));

  p_zero_class_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cls_w == CLS_ZERO) |=> (out_int == '0 && !out_inexact && !out_operr));

  p_special_sat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_class[1]) |=>
      (out_operr && !out_inexact && out_int == ($past(in_sign) ? NEG_SAT : POS_SAT)));

  p_big_exp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cls_w == CLS_NUM && exp_big_w) |=> out_operr);

  p_neg_exp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cls_w == CLS_NUM && exp_w < 0) |=> (out_int == '0 && !out_operr));

  p_sign_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cls_w == CLS_NUM && !ovf_w && mag_w != '0) |=>
      (out_int[INT_W-1] == $past(in_sign)));

endmodule

// File: tb/sim_fp2int_conv.sv
module sim_fp2int_conv;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  in_class = 2'b00;
  logic        in_sign = 1'b0;
  logic [15:0] in_exp = '0;
  logic [39:0] in_mant = '0;
  logic        in_sticky = 1'b0;
  logic        out_valid;
  logic [31:0] out_int;
  logic        out_inexact;
  logic        out_operr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  fp2int_conv u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class),
    .in_sign(in_sign), .in_exp(in_exp), .in_mant(in_mant), .in_sticky(in_sticky),
    .out_valid(out_valid), .out_int(out_int), .out_inexact(out_inexact),
    .out_operr(out_operr)
  );

  // {tag, class, sign, exp, mant, sticky, exp_int, exp_inexact, exp_operr}
  localparam int NV = 22;
  localparam logic [97:0] VEC [NV] = '{
    {4'd1, 2'b00,1'b1,16'h0005,40'hFF_FFFF_FFFF,1'b1,32'h0000_0000,1'b0,1'b0}, // R1
    {4'd4, 2'b01,1'b0,16'h0000,40'h80_0000_0000,1'b0,32'h0000_0001,1'b0,1'b0}, // R4 1.0
    {4'd5, 2'b01,1'b0,16'h0000,40'hC0_0000_0000,1'b0,32'h0000_0001,1'b1,1'b0}, // R5 1.5
    {4'd8, 2'b01,1'b1,16'h0000,40'hC0_0000_0000,1'b0,32'hFFFF_FFFF,1'b1,1'b0}, // R8 -1.5 -> -1
    {4'd4, 2'b01,1'b0,16'h0003,40'hA0_0000_0000,1'b0,32'h0000_000A,1'b0,1'b0}, // R4 10
    {4'd8, 2'b01,1'b1,16'h0003,40'hA0_0000_0000,1'b0,32'hFFFF_FFF6,1'b0,1'b0}, // R8 -10
    {4'd5, 2'b01,1'b0,16'h0003,40'h80_0000_0000,1'b1,32'h0000_0008,1'b1,1'b0}, // R5 sticky only
    {4'd4, 2'b01,1'b0,16'h0004,40'hBC_0000_0000,1'b0,32'h0000_0017,1'b1,1'b0}, // R4 23.5 -> 23
    {4'd6, 2'b01,1'b0,16'hFFFF,40'h80_0000_0000,1'b0,32'h0000_0000,1'b1,1'b0}, // R6 0.5
    {4'd6, 2'b01,1'b1,16'hB1E0,40'h80_0000_0000,1'b0,32'h0000_0000,1'b1,1'b0}, // R6 tiny neg
    {4'd6, 2'b01,1'b1,16'h8000,40'h80_0000_0000,1'b1,32'h0000_0000,1'b1,1'b0}, // R6 most negative exp
    {4'd7, 2'b01,1'b0,16'h001F,40'h80_0000_0000,1'b0,32'h7FFF_FFFF,1'b0,1'b1}, // R7 +2^31 overflows
    {4'd7, 2'b01,1'b1,16'h001F,40'h80_0000_0000,1'b0,32'h8000_0000,1'b0,1'b0}, // R7 -2^31 fits
    {4'd7, 2'b01,1'b1,16'h001F,40'h80_0000_0001,1'b0,32'h8000_0000,1'b1,1'b0}, // R7 fits, inexact
    {4'd7, 2'b01,1'b1,16'h001F,40'h80_0000_0100,1'b0,32'h8000_0000,1'b0,1'b1}, // R7 just past edge
    {4'd5, 2'b01,1'b0,16'h001E,40'hFF_FFFF_FFFF,1'b0,32'h7FFF_FFFF,1'b1,1'b0}, // R5 largest fitting
    {4'd7, 2'b01,1'b0,16'h001F,40'hFF_FFFF_FF00,1'b0,32'h7FFF_FFFF,1'b0,1'b1}, // R7 big positive
    {4'd3, 2'b01,1'b0,16'h0020,40'h80_0000_0000,1'b0,32'h7FFF_FFFF,1'b0,1'b1}, // R3 exp 32
    {4'd3, 2'b01,1'b1,16'h7FFF,40'h80_0000_0000,1'b1,32'h8000_0000,1'b0,1'b1}, // R3 huge exp
    {4'd2, 2'b10,1'b0,16'h0000,40'h00_0000_0000,1'b0,32'h7FFF_FFFF,1'b0,1'b1}, // R2 +inf
    {4'd2, 2'b10,1'b1,16'h0000,40'h00_0000_0000,1'b0,32'h8000_0000,1'b0,1'b1}, // R2 -inf
    {4'd2, 2'b11,1'b1,16'h0000,40'hC0_0000_0000,1'b1,32'h8000_0000,1'b0,1'b1}  // R2 NaN, R10
  };

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
    end
  endtask

  initial begin
    logic [31:0] last_int;
    repeat (3) @(negedge clk);
    // R11: reset state
    check(out_valid == 1'b0 && out_int == 32'h0 && !out_inexact && !out_operr,
          "R11 reset", {out_valid, out_inexact, out_operr, out_int[28:0]}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R9 idle after reset", {31'h0, out_valid}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [97:0] v;
      v = VEC[i];
      in_valid  = 1'b1;
      in_class  = v[93:92];
      in_sign   = v[91];
      in_exp    = v[90:75];
      in_mant   = v[74:35];
      in_sticky = v[34];
      @(negedge clk);
      checks++;
      if (!(out_valid && out_int == v[33:2] && out_inexact == v[1] && out_operr == v[0])) begin
        fails++;
        $display("FAIL R%0d vec %0d actual=%h/%b%b/v%b expected=%h/%b%b",
                 v[97:94], i, out_int, out_inexact, out_operr, out_valid,
                 v[33:2], v[1], v[0]);
      end
    end

    // R9: idle cycle drops valid, holds result and flags
    last_int = out_int;
    in_valid = 1'b0;
    in_class = 2'b01; in_sign = 1'b0; in_exp = 16'h0000;
    in_mant  = 40'hC0_0000_0000; in_sticky = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R9 valid falls", {31'h0, out_valid}, 32'h0);
    check(out_int == last_int && out_operr && !out_inexact,
          "R9 hold while idle", out_int, last_int);

    // R9: inexact flag from one operand does not survive the next
    in_valid = 1'b1;
    @(negedge clk);
    check(out_int == 32'h1 && out_inexact && !out_operr, "R5 set before clear",
          out_int, 32'h1);
    in_mant = 40'h80_0000_0000;
    @(negedge clk);
    check(out_int == 32'h1 && !out_inexact && !out_operr, "R9 flags replaced",
          {30'h0, out_inexact, out_operr}, 32'h0);
    // R10: NaN with sticky keeps inexact low
    in_class = 2'b11; in_sticky = 1'b1;
    @(negedge clk);
    check(out_operr && !out_inexact, "R10 exclusive flags",
          {30'h0, out_inexact, out_operr}, 32'h1);
    in_valid = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule